// File: doc/BRIEF.md
# LCD Sync Timing Generator for a Byte-Wide Pixel Port

The block produces the line sync, the frame sync and a data-valid window for a 320 by 240 TFT panel. The panel is driven over an 8-bit parallel port, so every pixel takes several port clocks. All timing is therefore counted in port clocks. A colour mode sets the clocks-per-pixel factor: two clocks for 16-bit 5-6-5 colour and three for 24-bit 8-8-8 colour.

The first valid pixel of each line is pushed late by a mode-dependent pipeline delay. This covers the latency of an external byte-packing stage that sits between the data source and the panel.

When enable rises, the frame timer starts one port clock before the line timer. The frame sync therefore always leads the line sync. When enable drops, all counters return to zero and all outputs go idle. The colour mode is captured only while the block is disabled.

Top module: `lcd_sync_gen`

## Requirements
- R1: On every active line, de stays high for exactly 320 x cpp consecutive port clocks. cpp is 2 when mode_sel_i = 0 (5-6-5) and 3 when mode_sel_i = 1 (8-8-8).
- R2: The line period is 336 x cpp port clocks. hsync_n is low for the first 2 x cpp clocks of each line.
- R3: de rises 7 x cpp + D port clocks after the line start, measured from the first low clock of hsync_n. D is 3 in 5-6-5 mode and 5 in 8-8-8 mode.
- R4: A frame is 244 lines. vsync_n is low for the first 2 x cpp clocks of each frame and repeats every 244 line periods.
- R5: After enable, vsync_n goes low one port clock before hsync_n first goes low. line_cnt_o is 0 at that first hsync_n fall.
- R6: line_cnt_o counts 0 to 243. de is high only on lines 2 to 241. Lines 0, 1, 242 and 243 are blanking.
- R7: mode_sel_i is sampled only while en_i is low. A change of mode_sel_i while enabled has no effect on any output.
- R8: When en_i is low, or rst_i is high, the outputs at the next clock edge are hsync_n = 1, vsync_n = 1, de = 0, pix_cnt_o = 0 and line_cnt_o = 0.
- R9: pix_cnt_o counts port clocks from 0 at the start of each line (the first low clock of hsync_n). It is aligned with the sync and de outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds the block idle |
| mode_sel_i | input | 1 | Colour mode: 0 = 5-6-5, 1 = 8-8-8 |
| hsync_n_o | output | 1 | Line sync, active low |
| vsync_n_o | output | 1 | Frame sync, active low |
| de_o | output | 1 | Data-valid window |
| pix_cnt_o | output | HW | Port clock position within the line |
| line_cnt_o | output | VW | Line index within the frame |

## Verification
The bench runs the generator in both colour modes. The first-pixel offset and window length differ by mode, so a swapped clocks-per-pixel factor or pipeline delay is caught.

The 5-6-5 run covers a full frame and wraps into the next. This exercises the trailing blanking lines, the line-counter wrap and the second frame sync.

The 8-8-8 run toggles the mode input while enabled, then drops enable in the middle of a data window. This separates a correctly latched mode from a live one, and shows that disabling returns every output to idle at once.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  typedef enum logic {
    MODE_RGB565 = 1'b0,
    MODE_RGB888 = 1'b1
  } color_mode_e;
endpackage

// File: rtl/lcd_sync_mode_cfg.sv
module lcd_sync_mode_cfg
  import lcd_sync_pkg::*;
#(
  parameter int H_ACT      = 320,
  parameter int H_TOT_PIX  = 336,
  parameter int H_SYNC_PIX = 2,
  parameter int H_LEAD_PIX = 7,
  parameter int V_SYNC_PIX = 2,
  parameter int V_TOT      = 244,
  parameter int CPP_A      = 2,
  parameter int CPP_B      = 3,
  parameter int DLY_A      = 3,
  parameter int DLY_B      = 5,
  parameter int HW         = 10,
  parameter int FW         = 18
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             mode_sel_i,
  output color_mode_e      mode_q_o,
  output logic [HW-1:0]    hper_o,
  output logic [HW-1:0]    hsw_o,
  output logic [HW-1:0]    vsw_o,
  output logic [HW-1:0]    de_beg_o,
  output logic [HW-1:0]    de_end_o,
  output logic [FW-1:0]    fper_o
);
  logic [HW-1:0] cpp;
  logic [HW-1:0] dly;

  // mode is captured only while the generator is stopped
  always_ff @(posedge clk_i) begin
    if (rst_i)      mode_q_o <= MODE_RGB565;
    else if (!en_i) mode_q_o <= color_mode_e'(mode_sel_i);
  end

  always_comb begin
    cpp      = (mode_q_o == MODE_RGB888) ? HW'(CPP_B) : HW'(CPP_A);
    dly      = (mode_q_o == MODE_RGB888) ? HW'(DLY_B) : HW'(DLY_A);
    hper_o   = HW'(H_TOT_PIX) * cpp;
    hsw_o    = HW'(H_SYNC_PIX) * cpp;
    vsw_o    = HW'(V_SYNC_PIX) * cpp;
    de_beg_o = HW'(H_LEAD_PIX) * cpp + dly;
    de_end_o = de_beg_o + HW'(H_ACT) * cpp;
    fper_o   = FW'(hper_o) * FW'(V_TOT);
  end
endmodule

// File: rtl/lcd_sync_frame_timer.sv
module lcd_sync_frame_timer #(
  parameter int FW = 18
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic [FW-1:0] fper_i,
  output logic          run_o,
  output logic [FW-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      run_o <= 1'b0;
      cnt_o <= '0;
    end else if (!run_o) begin
      run_o <= 1'b1;
      cnt_o <= '0;
    end else if (cnt_o == fper_i - FW'(1)) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_o + FW'(1);
    end
  end
endmodule

// File: rtl/lcd_sync_line_timer.sv
module lcd_sync_line_timer #(
  parameter int V_TOT = 244,
  parameter int HW    = 10,
  parameter int VW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          go_i,
  input  logic [HW-1:0] hper_i,
  output logic          run_o,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o
);
  // starts one clock after the frame timer so frame sync leads line sync
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      run_o  <= 1'b0;
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else if (!run_o) begin
      run_o  <= go_i;
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else if (hcnt_o == hper_i - HW'(1)) begin
      hcnt_o <= '0;
      vcnt_o <= (vcnt_o == VW'(V_TOT - 1)) ? '0 : vcnt_o + VW'(1);
    end else begin
      hcnt_o <= hcnt_o + HW'(1);
    end
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int H_ACT      = 320,
  parameter int V_ACT      = 240,
  parameter int H_TOT_PIX  = 336,
  parameter int H_SYNC_PIX = 2,
  parameter int H_LEAD_PIX = 7,
  parameter int V_TOP      = 2,
  parameter int V_BOT      = 2,
  parameter int V_SYNC_PIX = 2,
  parameter int CPP_A      = 2,
  parameter int CPP_B      = 3,
  parameter int DLY_A      = 3,
  parameter int DLY_B      = 5,
  localparam int V_TOT     = V_ACT + V_TOP + V_BOT,
  localparam int HW        = $clog2(H_TOT_PIX * CPP_B + 1),
  localparam int VW        = $clog2(V_TOT + 1),
  localparam int FW        = $clog2(H_TOT_PIX * CPP_B * V_TOT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          mode_sel_i,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          de_o,
  output logic [HW-1:0] pix_cnt_o,
  output logic [VW-1:0] line_cnt_o
);
  color_mode_e   mode_q;
  logic [HW-1:0] hper, hsw, vsw, de_beg, de_end;
  logic [FW-1:0] fper, fcnt;
  logic          frun, hrun;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  lcd_sync_mode_cfg #(
    .H_ACT(H_ACT), .H_TOT_PIX(H_TOT_PIX), .H_SYNC_PIX(H_SYNC_PIX),
    .H_LEAD_PIX(H_LEAD_PIX), .V_SYNC_PIX(V_SYNC_PIX), .V_TOT(V_TOT),
    .CPP_A(CPP_A), .CPP_B(CPP_B), .DLY_A(DLY_A), .DLY_B(DLY_B),
    .HW(HW), .FW(FW)
  ) cfg_i (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .mode_sel_i(mode_sel_i),
    .mode_q_o(mode_q), .hper_o(hper), .hsw_o(hsw), .vsw_o(vsw),
    .de_beg_o(de_beg), .de_end_o(de_end), .fper_o(fper)
  );

  lcd_sync_frame_timer #(.FW(FW)) frame_i (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .fper_i(fper),
    .run_o(frun), .cnt_o(fcnt)
  );

  lcd_sync_line_timer #(.V_TOT(V_TOT), .HW(HW), .VW(VW)) line_i (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .go_i(frun), .hper_i(hper),
    .run_o(hrun), .hcnt_o(hcnt), .vcnt_o(vcnt)
  );

  // registered outputs, one clock behind the counters, all aligned
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      hsync_n_o  <= 1'b1;
      vsync_n_o  <= 1'b1;
      de_o       <= 1'b0;
      pix_cnt_o  <= '0;
      line_cnt_o <= '0;
    end else begin
      vsync_n_o  <= !(frun && (fcnt < FW'(vsw)));
      hsync_n_o  <= !(hrun && (hcnt < hsw));
      de_o       <= hrun && (vcnt >= VW'(V_TOP)) && (vcnt < VW'(V_TOP + V_ACT))
                    && (hcnt >= de_beg) && (hcnt < de_end);
      pix_cnt_o  <= hcnt;
      line_cnt_o <= vcnt;
    end
  end
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int H_ACT      = 320,
  parameter int V_ACT      = 240,
  parameter int V_TOP      = 2,
  parameter int V_TOT      = 244,
  parameter int H_SYNC_PIX = 2,
  parameter int V_SYNC_PIX = 2,
  parameter int CPP_A      = 2,
  parameter int CPP_B      = 3,
  parameter int HW         = 10,
  parameter int VW         = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          mode_q,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          de,
  input logic [HW-1:0] pix_cnt,
  input logic [VW-1:0] line_cnt
);
  int cpp;
  logic [15:0] hs_run, vs_run, de_run;

  assign cpp = mode_q ? CPP_B : CPP_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_run <= '0;
      vs_run <= '0;
      de_run <= '0;
    end else begin
      hs_run <= hsync_n ? '0 : hs_run + 16'd1;
      vs_run <= vsync_n ? '0 : vs_run + 16'd1;
      de_run <= de ? de_run + 16'd1 : '0;
    end
  end

  p_de_len_r1: assert property (@(posedge clk) disable iff (rst)
    ($fell(de) && en && $past(en)) |-> (int'(de_run) == H_ACT * cpp));

  p_hs_width_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(hsync_n) && en && $past(en)) |-> (int'(hs_run) == H_SYNC_PIX * cpp));

  p_vs_width_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsync_n) && en && $past(en)) |-> (int'(vs_run) == V_SYNC_PIX * cpp));

  p_vs_lead_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(hsync_n) && line_cnt == '0) |-> (!vsync_n && $past(!vsync_n)));

  p_de_blank_r6: assert property (@(posedge clk) disable iff (rst)
    de |-> (line_cnt >= VW'(V_TOP) && line_cnt < VW'(V_TOP + V_ACT)));

  p_line_range_r6: assert property (@(posedge clk) disable iff (rst)
    line_cnt < VW'(V_TOT));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(mode_q));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (hsync_n && vsync_n && !de && pix_cnt == '0 && line_cnt == '0));

  p_pix_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> (pix_cnt == '0));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(
  .H_ACT(H_ACT), .V_ACT(V_ACT), .V_TOP(V_TOP), .V_TOT(V_TOT),
  .H_SYNC_PIX(H_SYNC_PIX), .V_SYNC_PIX(V_SYNC_PIX),
  .CPP_A(CPP_A), .CPP_B(CPP_B), .HW(HW), .VW(VW)
) chk_i (
  .clk(clk_i), .rst(rst_i), .en(en_i), .mode_q(mode_q),
  .hsync_n(hsync_n_o), .vsync_n(vsync_n_o), .de(de_o),
  .pix_cnt(pix_cnt_o), .line_cnt(line_cnt_o)
);

// File: tb/lcd_sync_gen_tb_top.sv
module lcd_sync_gen_tb_top;
  localparam int HW = 10;
  localparam int VW = 8;

  typedef struct {
    int    due;
    logic  hs;
    logic  vs;
    logic  de;
    int    pix;
    int    line;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic mode_sel = 1'b1;
  logic hsync_n, vsync_n, de;
  logic [HW-1:0] pix_cnt;
  logic [VW-1:0] line_cnt;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  int ecnt = 0;
  logic model_mode = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  lcd_sync_gen dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .mode_sel_i(mode_sel),
    .hsync_n_o(hsync_n), .vsync_n_o(vsync_n), .de_o(de),
    .pix_cnt_o(pix_cnt), .line_cnt_o(line_cnt)
  );

  // Reference model written from the requirements
  function automatic exp_t predict(logic m, int e, int due, string tag);
    exp_t x;
    int cpp, dly, hper, fper, t, h, v, beg;
    cpp  = m ? 3 : 2;            // R1
    dly  = m ? 5 : 3;            // R3
    hper = 336 * cpp;            // R2
    fper = hper * 244;           // R4
    x.due = due; x.tag = tag;
    x.hs = 1'b1; x.vs = 1'b1; x.de = 1'b0; x.pix = 0; x.line = 0;
    if (e > 0) begin
      t = e - 1;
      x.vs = !((t % fper) < 2 * cpp);
      if (t > 0) begin
        h = (t - 1) % hper;
        v = ((t - 1) / hper) % 244;
        beg = 7 * cpp + dly;
        x.hs = !(h < 2 * cpp);
        x.de = (v >= 2) && (v < 242) && (h >= beg) && (h < beg + 320 * cpp);
        x.pix = h;
        x.line = v;
      end
    end
    return x;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(logic r, logic e, logic ms, string tag);
    @(negedge clk);
    rst = r; en = e; mode_sel = ms;
    if (r || !e) begin
      q.push_back(predict(model_mode, 0, cyc + 1, tag));
      ecnt = 0;
      if (r) model_mode = 1'b0;
      else   model_mode = ms;       // R7: captured only while stopped
    end else begin
      q.push_back(predict(model_mode, ecnt, cyc + 1, tag));
      ecnt++;
    end
  endtask

  task automatic cmp(string tag, string what, int got, int expv);
    n_vec++;
    if (got != expv) begin
      n_bad++;
      if (n_bad <= 20)
        $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, expv);
    end
  endtask

  // Monitor: compares each due item away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t x;
      x = q.pop_front();
      cmp({x.tag, " R2"}, "hsync_n", int'(hsync_n), int'(x.hs));
      cmp({x.tag, " R4 R5"}, "vsync_n", int'(vsync_n), int'(x.vs));
      cmp({x.tag, " R1 R3 R6"}, "de", int'(de), int'(x.de));
      cmp({x.tag, " R9"}, "pix_cnt", int'(pix_cnt), x.pix);
      cmp({x.tag, " R6"}, "line_cnt", int'(line_cnt), x.line);
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // reset state, R8
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b1, "R8 reset");
    for (int i = 0; i < 2; i++) drive(1'b0, 1'b0, 1'b1, "R8 idle");
    // 8-8-8 mode; mode input toggled while running must be ignored (R7)
    for (int i = 0; i < 4200; i++)
      drive(1'b0, 1'b1, (i < 3000) ? 1'b1 : 1'b0, (i < 3000) ? "R3 rgb888" : "R7 mode_ignored");
    // disable in the middle of a data window, switch to 5-6-5 (R8)
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0, "R8 disabled");
    // full 5-6-5 frame plus the start of the next (R4 R6 wrap)
    for (int i = 0; i < 164100; i++) drive(1'b0, 1'b1, 1'b0, "R4 rgb565_frame");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule